// File: doc/BRIEF.md
# Timer Capture/Compare Channel with Output Unit

This block is one channel of a general-purpose timer. It sits beside a shared free-running or modulus counter, which it does not own: it sees the counter value and a one-cycle timer tick, and it holds one reference register. In compare mode the channel raises an equality event on a tick cycle whose counter value equals the reference. That event sets the channel's event flag and drives a registered output pin through one of eight output behaviours. Some of these behaviours also use the equality event of channel 0 as a period boundary, which gives edge-aligned and centre-aligned pulse-width modulation.

In capture mode the channel watches one of four sources: two external pins, a constant low or a constant high. Software can force a capture by flipping the source between the two constants. The chosen source passes through a synchronizer, and on the selected edge the channel copies the counter value into the reference register. The copy can happen at once, or it can be held until the next timer tick. A second capture that arrives while the event flag is still set raises an overflow flag. The channel exports its own equality event so that its neighbours can use it as their boundary. When the channel is built as channel 0, its own event serves as the boundary.

Top module: `ccu_channel`

## Requirements
- R1: After reset the output, the event flag, the overflow flag, the interrupt request and the reference register are all 0, and the channel is in compare mode when `cap_mode` is 0.
- R2: In compare mode (`cap_mode`=0), a cycle with `tick`=1 and `count` equal to `ref_q` sets `flag` at that clock edge and pulses `eq_evt`. A matching count with `tick`=0 does nothing. `irq` is high whenever both `flag` and `irq_en` are high.
- R3: With `out_mode`=0, `ch_out` takes the value of `out_bit` at the next clock edge.
- R4: With `out_mode` 1, 4 or 5, the channel's own equality event sets, toggles or clears `ch_out` respectively. The boundary event has no effect in these modes. In modes 1 to 7, `ch_out` holds when no event occurs.
- R5: In `out_mode` 2 the own event toggles `ch_out`, and in `out_mode` 3 it sets `ch_out`. In both modes the boundary event clears `ch_out`, and the boundary wins when both events fall in the same cycle.
- R6: In `out_mode` 6 the own event toggles `ch_out`, and in `out_mode` 7 it clears `ch_out`. In both modes the boundary event sets `ch_out`, and the boundary wins when both events fall in the same cycle.
- R7: A channel built with `IS_CHAN0`=1 ignores `bnd_evt_in` and uses its own equality event as the boundary. Mode 3 therefore clears on a match, and modes 6 and 7 set on a match.
- R8: `edge_sel` selects the capture edge: 0 none, 1 rising, 2 falling, 3 both. With `sync_en`=0, a source edge is captured on the third clock edge after it, when `ref_q` takes `count` and `flag` sets.
- R9: `src_sel` selects the capture source: 0 `in_a`, 1 `in_b`, 2 constant 0, 3 constant 1. Moving from 2 to 3 triggers a rising capture. `cci_level` shows the synchronized source level two clock edges after a change.
- R10: With `sync_en`=1, a detected edge waits for a cycle with `tick`=1 and then captures the `count` of that cycle.
- R11: `ovf` sets when a capture occurs while `flag` is already set. `ovf` is cleared by `ovf_clr`.
- R12: At each compare equality event, `cci_sampled` takes the current `cci_level`, and it holds between events.
- R13: `flag_clr` clears `flag`. A new event in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timer clock enable, one cycle per count |
| count | input | CNT_W | Shared counter value |
| bnd_evt_in | input | 1 | Channel 0 equality event (period boundary) |
| cap_mode | input | 1 | 1 capture, 0 compare |
| edge_sel | input | 2 | Capture edge: none, rise, fall, both |
| src_sel | input | 2 | Capture source: A, B, low, high |
| sync_en | input | 1 | Defer capture to next tick |
| in_a | input | 1 | Capture input A (asynchronous) |
| in_b | input | 1 | Capture input B (asynchronous) |
| out_mode | input | 3 | Output behaviour 0..7 |
| out_bit | input | 1 | Software output level for mode 0 |
| irq_en | input | 1 | Interrupt enable |
| ref_wr | input | 1 | Reference register write strobe |
| ref_wdata | input | CNT_W | Reference write data |
| flag_clr | input | 1 | Event flag clear strobe |
| ovf_clr | input | 1 | Overflow flag clear strobe |
| ref_q | output | CNT_W | Reference register value |
| ch_out | output | 1 | Channel output |
| flag | output | 1 | Event flag |
| ovf | output | 1 | Capture overflow flag |
| irq | output | 1 | Interrupt request |
| cci_level | output | 1 | Synchronized source level |
| cci_sampled | output | 1 | Source level sampled at the last compare event |
| eq_evt | output | 1 | This channel's equality event |

## Verification
The assertions check the invariants every cycle. An equality event always leaves the flag set. The output holds in modes 1 to 7 when no event occurs. A boundary event forces the output to the level the mode calls for. The overflow flag only rises over an already-set flag. The reference register changes in compare mode only when it is written. The directed scenarios are the only way to show the exact toggle sequences under coincident events, the three-edge capture latency, the deferral of synchronized captures to a tick, software-triggered captures through the constant sources, and the channel-0 variant.

// File: rtl/ccu_pkg.sv
package ccu_pkg;
  typedef enum logic [2:0] {
    OM_SWBIT   = 3'd0,
    OM_SET     = 3'd1,
    OM_TGL_CLR = 3'd2,
    OM_SET_CLR = 3'd3,
    OM_TGL     = 3'd4,
    OM_CLR     = 3'd5,
    OM_TGL_SET = 3'd6,
    OM_CLR_SET = 3'd7
  } outmode_e;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_ANY  = 2'd3
  } edge_e;

  typedef enum logic [1:0] {
    SRC_A  = 2'd0,
    SRC_B  = 2'd1,
    SRC_LO = 2'd2,
    SRC_HI = 2'd3
  } src_e;

  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/ccu_cap_path.sv
module ccu_cap_path
  import ccu_pkg::*;
#(
  parameter int unsigned STAGES = SYNC_STAGES
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cap_en,
  input  logic       tick,
  input  logic       in_a,
  input  logic       in_b,
  input  logic [1:0] src_sel,
  input  logic [1:0] edge_sel,
  input  logic       sync_en,
  output logic       level,
  output logic       fire
);
  logic              src_lvl;
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              pend_q, pend_d;
  logic              rise, fall, edge_hit, trig;

  always_comb begin
    unique case (src_e'(src_sel))
      SRC_A:   src_lvl = in_a;
      SRC_B:   src_lvl = in_b;
      SRC_LO:  src_lvl = 1'b0;
      default: src_lvl = 1'b1;
    endcase
  end

  assign level = sync_q[STAGES-1];
  assign rise  = level & ~prev_q;
  assign fall  = ~level & prev_q;

  always_comb begin
    unique case (edge_e'(edge_sel))
      EDGE_NONE: edge_hit = 1'b0;
      EDGE_RISE: edge_hit = rise;
      EDGE_FALL: edge_hit = fall;
      default:   edge_hit = rise | fall;
    endcase
  end

  assign trig   = cap_en & (edge_hit | pend_q);
  assign fire   = sync_en ? (trig & tick) : (cap_en & edge_hit);
  assign pend_d = cap_en & sync_en & trig & ~tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], src_lvl};
      prev_q <= level;
      pend_q <= pend_d;
    end
  end

  // R10: an edge held for a synchronized capture is not lost while ticks are absent
  a_r10_pend_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && sync_en && pend_q && !tick) |=> (pend_q || !cap_en || !sync_en));
endmodule

// File: rtl/ccu_cmp_path.sv
module ccu_cmp_path #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_en,
  input  logic             tick,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] ref_val,
  input  logic             level,
  output logic             eq_evt,
  output logic             sampled
);
  logic samp_q, samp_d;

  assign eq_evt  = cmp_en & tick & (count == ref_val);
  assign samp_d  = eq_evt ? level : samp_q;
  assign sampled = samp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) samp_q <= 1'b0;
    else        samp_q <= samp_d;
  end

  // R12: the sampled level only moves at an equality event
  a_r12_sample_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !eq_evt |=> $stable(sampled));
endmodule

// File: rtl/ccu_out_unit.sv
module ccu_out_unit
  import ccu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode,
  input  logic       sw_bit,
  input  logic       own_evt,
  input  logic       bnd_evt,
  output logic       out
);
  logic out_q, out_d;

  always_comb begin
    out_d = out_q;
    unique case (outmode_e'(mode))
      OM_SWBIT:   out_d = sw_bit;
      OM_SET:     if (own_evt) out_d = 1'b1;
      OM_TGL_CLR: if (bnd_evt) out_d = 1'b0; else if (own_evt) out_d = ~out_q;
      OM_SET_CLR: if (bnd_evt) out_d = 1'b0; else if (own_evt) out_d = 1'b1;
      OM_TGL:     if (own_evt) out_d = ~out_q;
      OM_CLR:     if (own_evt) out_d = 1'b0;
      OM_TGL_SET: if (bnd_evt) out_d = 1'b1; else if (own_evt) out_d = ~out_q;
      default:    if (bnd_evt) out_d = 1'b1; else if (own_evt) out_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= out_d;
  end

  assign out = out_q;

  // R3: mode 0 follows the software bit one edge later
  a_r3_sw_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd0) |=> (out == $past(sw_bit)));
  // R4: no event, no change outside mode 0
  a_r4_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 3'd0 && !own_evt && !bnd_evt) |=> $stable(out));
  // R5: boundary clears in modes 2 and 3
  a_r5_bnd_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (bnd_evt && (mode == 3'd2 || mode == 3'd3)) |=> !out);
  // R6: boundary sets in modes 6 and 7
  a_r6_bnd_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (bnd_evt && (mode == 3'd6 || mode == 3'd7)) |=> out);
endmodule

// File: rtl/ccu_channel.sv
module ccu_channel
  import ccu_pkg::*;
#(
  parameter int unsigned CNT_W    = 16,
  parameter bit          IS_CHAN0 = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] count,
  input  logic             bnd_evt_in,
  input  logic             cap_mode,
  input  logic [1:0]       edge_sel,
  input  logic [1:0]       src_sel,
  input  logic             sync_en,
  input  logic             in_a,
  input  logic             in_b,
  input  logic [2:0]       out_mode,
  input  logic             out_bit,
  input  logic             irq_en,
  input  logic             ref_wr,
  input  logic [CNT_W-1:0] ref_wdata,
  input  logic             flag_clr,
  input  logic             ovf_clr,
  output logic [CNT_W-1:0] ref_q,
  output logic             ch_out,
  output logic             flag,
  output logic             ovf,
  output logic             irq,
  output logic             cci_level,
  output logic             cci_sampled,
  output logic             eq_evt
);
  logic [CNT_W-1:0] ref_r, ref_d;
  logic             flag_r, flag_d;
  logic             ovf_r, ovf_d;
  logic             cap_fire, own_eq, bnd_evt;

  ccu_cap_path #(.STAGES(SYNC_STAGES)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_en   (cap_mode),
    .tick     (tick),
    .in_a     (in_a),
    .in_b     (in_b),
    .src_sel  (src_sel),
    .edge_sel (edge_sel),
    .sync_en  (sync_en),
    .level    (cci_level),
    .fire     (cap_fire)
  );

  ccu_cmp_path #(.CNT_W(CNT_W)) u_cmp (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmp_en  (~cap_mode),
    .tick    (tick),
    .count   (count),
    .ref_val (ref_r),
    .level   (cci_level),
    .eq_evt  (own_eq),
    .sampled (cci_sampled)
  );

  generate
    if (IS_CHAN0) begin : g_self_bnd
      logic unused_bnd;
      assign unused_bnd = bnd_evt_in;
      assign bnd_evt    = own_eq;
    end else begin : g_ext_bnd
      assign bnd_evt = bnd_evt_in;
    end
  endgenerate

  ccu_out_unit u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (out_mode),
    .sw_bit  (out_bit),
    .own_evt (own_eq),
    .bnd_evt (bnd_evt),
    .out     (ch_out)
  );

  always_comb begin
    ref_d  = ref_r;
    if (cap_fire)    ref_d = count;
    else if (ref_wr) ref_d = ref_wdata;

    flag_d = flag_r;
    if (cap_fire || own_eq) flag_d = 1'b1;
    else if (flag_clr)      flag_d = 1'b0;

    ovf_d  = ovf_r;
    if (cap_fire && flag_r) ovf_d = 1'b1;
    else if (ovf_clr)       ovf_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_r  <= '0;
      flag_r <= 1'b0;
      ovf_r  <= 1'b0;
    end else begin
      ref_r  <= ref_d;
      flag_r <= flag_d;
      ovf_r  <= ovf_d;
    end
  end

  assign ref_q  = ref_r;
  assign flag   = flag_r;
  assign ovf    = ovf_r;
  assign irq    = flag_r & irq_en;
  assign eq_evt = own_eq;

  // R2: an equality event always leaves the flag set
  a_r2_flag_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    eq_evt |=> flag);
  // R11: overflow only rises over an already-set flag
  a_r11_ovf_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !$past(ovf)) |-> $past(flag));
  // R8: in compare mode the reference changes only by a write
  a_r8_ref_hold_cmp: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_mode && !ref_wr) |=> $stable(ref_q));
  // R2: interrupt never asserted without its enable
  a_r2_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);
endmodule

// File: tb/ccu_channel_test.sv
module ccu_channel_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick, bnd_evt_in, cap_mode, sync_en, in_a, in_b, out_bit, irq_en;
  logic        ref_wr, flag_clr, ovf_clr;
  logic [15:0] count, ref_wdata;
  logic [1:0]  edge_sel, src_sel;
  logic [2:0]  out_mode;
  logic [15:0] ref_q, ref_q0;
  logic        ch_out, flag, ovf, irq, cci_level, cci_sampled, eq_evt;
  logic        ch_out0, flag0, ovf0, irq0, lvl0, smp0, eq0;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done  = 1'b0;

  always #5 clk = ~clk;

  ccu_channel #(.CNT_W(16), .IS_CHAN0(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .count(count), .bnd_evt_in(bnd_evt_in),
    .cap_mode(cap_mode), .edge_sel(edge_sel), .src_sel(src_sel), .sync_en(sync_en),
    .in_a(in_a), .in_b(in_b), .out_mode(out_mode), .out_bit(out_bit), .irq_en(irq_en),
    .ref_wr(ref_wr), .ref_wdata(ref_wdata), .flag_clr(flag_clr), .ovf_clr(ovf_clr),
    .ref_q(ref_q), .ch_out(ch_out), .flag(flag), .ovf(ovf), .irq(irq),
    .cci_level(cci_level), .cci_sampled(cci_sampled), .eq_evt(eq_evt));

  ccu_channel #(.CNT_W(16), .IS_CHAN0(1'b1)) uut0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .count(count), .bnd_evt_in(bnd_evt_in),
    .cap_mode(cap_mode), .edge_sel(edge_sel), .src_sel(src_sel), .sync_en(sync_en),
    .in_a(in_a), .in_b(in_b), .out_mode(out_mode), .out_bit(out_bit), .irq_en(irq_en),
    .ref_wr(ref_wr), .ref_wdata(ref_wdata), .flag_clr(flag_clr), .ovf_clr(ovf_clr),
    .ref_q(ref_q0), .ch_out(ch_out0), .flag(flag0), .ovf(ovf0), .irq(irq0),
    .cci_level(lvl0), .cci_sampled(smp0), .eq_evt(eq0));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_ref(input logic [15:0] v);
    ref_wr = 1'b1; ref_wdata = v; cyc(); ref_wr = 1'b0;
  endtask

  task automatic clr_flag();
    flag_clr = 1'b1; cyc(); flag_clr = 1'b0;
  endtask

  task automatic hit(input bit own, input bit bnd);
    tick = 1'b1; count = own ? 16'd10 : 16'd11; bnd_evt_in = bnd;
    cyc();
    tick = 1'b0; bnd_evt_in = 1'b0;
  endtask

  task automatic force_out(input logic v);
    out_mode = 3'd0; out_bit = v; cyc();
  endtask

  task automatic t_reset();
    chk("R1 out", ch_out, 0); chk("R1 flag", flag, 0); chk("R1 ovf", ovf, 0);
    chk("R1 ref", ref_q, 0);  chk("R1 irq", irq, 0);
  endtask

  task automatic t_compare();
    set_ref(16'd5);
    tick = 1'b1; count = 16'd4; cyc(); chk("R2 nomatch", flag, 0);
    count = 16'd5; #1 chk("R2 eq_evt", eq_evt, 1); cyc(); chk("R2 match", flag, 1);
    tick = 1'b0;
    chk("R2 irq off", irq, 0);
    irq_en = 1'b1; #1 chk("R2 irq on", irq, 1);
    clr_flag(); chk("R13 clear", flag, 0); chk("R2 irq after clr", irq, 0);
    count = 16'd5; cyc(); chk("R2 no tick", flag, 0);
    tick = 1'b1; flag_clr = 1'b1; cyc(); flag_clr = 1'b0; tick = 1'b0;
    chk("R13 set wins", flag, 1);
    clr_flag(); irq_en = 1'b0;
  endtask

  task automatic t_mode0();
    out_mode = 3'd0; out_bit = 1'b1; cyc(); chk("R3 high", ch_out, 1);
    out_bit = 1'b0; cyc(); chk("R3 low", ch_out, 0);
  endtask

  task automatic t_mode145();
    set_ref(16'd10);
    force_out(0); out_mode = 3'd1;
    tick = 1'b1; count = 16'd3; cyc(); tick = 1'b0; chk("R4 idle hold", ch_out, 0);
    hit(0, 1); chk("R4 m1 bnd ignored", ch_out, 0);
    hit(1, 0); chk("R4 m1 set", ch_out, 1);
    out_mode = 3'd4;
    hit(1, 0); chk("R4 m4 tgl a", ch_out, 0);
    hit(1, 0); chk("R4 m4 tgl b", ch_out, 1);
    out_mode = 3'd5;
    hit(0, 1); chk("R4 m5 bnd ignored", ch_out, 1);
    hit(1, 0); chk("R4 m5 clr", ch_out, 0);
  endtask

  task automatic t_mode23();
    force_out(0); out_mode = 3'd2;
    hit(1, 0); chk("R5 m2 tgl a", ch_out, 1);
    hit(1, 0); chk("R5 m2 tgl b", ch_out, 0);
    hit(1, 0); chk("R5 m2 tgl c", ch_out, 1);
    hit(0, 1); chk("R5 m2 bnd", ch_out, 0);
    hit(1, 0); hit(1, 1); chk("R5 m2 both", ch_out, 0);
    out_mode = 3'd3;
    hit(1, 0); chk("R5 m3 set", ch_out, 1);
    hit(0, 1); chk("R5 m3 bnd", ch_out, 0);
    hit(1, 0); hit(1, 1); chk("R5 m3 both", ch_out, 0);
  endtask

  task automatic t_mode67();
    force_out(0); out_mode = 3'd6;
    hit(0, 1); chk("R6 m6 bnd", ch_out, 1);
    hit(1, 0); chk("R6 m6 tgl", ch_out, 0);
    hit(1, 1); chk("R6 m6 both", ch_out, 1);
    out_mode = 3'd7;
    hit(1, 0); chk("R6 m7 clr", ch_out, 0);
    hit(0, 1); chk("R6 m7 bnd", ch_out, 1);
    hit(1, 0); hit(1, 1); chk("R6 m7 both", ch_out, 1);
  endtask

  task automatic t_chan0();
    force_out(0); out_mode = 3'd3;
    hit(1, 0); chk("R7 m3 self clr", ch_out0, 0); chk("R7 m3 other ch", ch_out, 1);
    force_out(0); out_mode = 3'd6;
    hit(1, 0); chk("R7 m6 self set", ch_out0, 1);
    hit(0, 1); chk("R7 ext bnd ignored", ch_out0, 1);
    force_out(0); out_mode = 3'd7;
    hit(1, 0); chk("R7 m7 self set", ch_out0, 1);
    force_out(0); clr_flag();
  endtask

  task automatic t_edges();
    cap_mode = 1'b1; sync_en = 1'b0; src_sel = 2'd0; in_a = 1'b0;
    edge_sel = 2'd1; tick = 1'b0; cyc(4); clr_flag();
    count = 16'd100; in_a = 1'b1; cyc(2);
    chk("R8 latency", flag, 0); chk("R9 level", cci_level, 1);
    cyc(); chk("R8 rise ref", ref_q, 100); chk("R8 rise flag", flag, 1);
    clr_flag();
    count = 16'd200; in_a = 1'b0; cyc(4);
    chk("R8 fall ignored", ref_q, 100); chk("R8 fall noflag", flag, 0);
    edge_sel = 2'd2; count = 16'd300; in_a = 1'b1; cyc(4);
    chk("R8 m2 rise ignored", ref_q, 100);
    in_a = 1'b0; cyc(3); chk("R8 fall ref", ref_q, 300); clr_flag();
    edge_sel = 2'd3; count = 16'd400; in_a = 1'b1; cyc(3);
    chk("R8 both rise", ref_q, 400); chk("R11 first no ovf", ovf, 0);
    count = 16'd500; in_a = 1'b0; cyc(3);
    chk("R8 both fall", ref_q, 500); chk("R11 ovf set", ovf, 1);
    ovf_clr = 1'b1; cyc(); ovf_clr = 1'b0; chk("R11 ovf clr", ovf, 0);
    clr_flag();
    edge_sel = 2'd0; count = 16'd600; in_a = 1'b1; cyc(4); in_a = 1'b0; cyc(4);
    chk("R8 none ref", ref_q, 500); chk("R8 none flag", flag, 0);
  endtask

  task automatic t_src();
    edge_sel = 2'd1; src_sel = 2'd1; in_b = 1'b0; cyc(3);
    count = 16'd640; in_a = 1'b1; cyc(4);
    chk("R9 A ignored", ref_q, 500); chk("R9 A noflag", flag, 0);
    count = 16'd650; in_b = 1'b1; cyc(3);
    chk("R9 B capture", ref_q, 650); chk("R9 B level", cci_level, 1);
    clr_flag(); in_b = 1'b0; in_a = 1'b0; cyc(4);
    src_sel = 2'd2; cyc(4); chk("R9 low level", cci_level, 0);
    count = 16'd700; src_sel = 2'd3; cyc(3);
    chk("R9 sw capture", ref_q, 700); chk("R9 sw flag", flag, 1);
    clr_flag();
  endtask

  task automatic t_sync();
    edge_sel = 2'd1; src_sel = 2'd2; cyc(4); clr_flag();
    sync_en = 1'b1; tick = 1'b0; count = 16'd800; src_sel = 2'd3; cyc(5);
    chk("R10 wait ref", ref_q, 700); chk("R10 wait flag", flag, 0);
    tick = 1'b1; count = 16'd900; cyc(); tick = 1'b0;
    chk("R10 tick ref", ref_q, 900); chk("R10 tick flag", flag, 1);
    clr_flag(); sync_en = 1'b0;
  endtask

  task automatic t_sample();
    cap_mode = 1'b0; cyc(); clr_flag();
    set_ref(16'd42);
    tick = 1'b1; count = 16'd42; cyc(); tick = 1'b0;
    chk("R12 sample high", cci_sampled, 1);
    src_sel = 2'd2; cyc(3);
    chk("R12 level low", cci_level, 0); chk("R12 held", cci_sampled, 1);
    tick = 1'b1; cyc(); tick = 1'b0;
    chk("R12 sample low", cci_sampled, 0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tick = 1'b0; count = '0; bnd_evt_in = 1'b0; cap_mode = 1'b0;
    edge_sel = '0; src_sel = '0; sync_en = 1'b0; in_a = 1'b0; in_b = 1'b0;
    out_mode = '0; out_bit = 1'b0; irq_en = 1'b0; ref_wr = 1'b0; ref_wdata = '0;
    flag_clr = 1'b0; ovf_clr = 1'b0;
    cyc(3); rst_n = 1'b1; cyc();
    t_reset();
    t_compare();
    t_mode0();
    t_mode145();
    t_mode23();
    t_mode67();
    t_chan0();
    t_edges();
    t_src();
    t_sync();
    t_sample();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule